// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block provides three independent 16-bit up-counters behind one small synchronous register port. A channel advances on a tick from its selected clock source. When the count equals the programmed target, the channel raises a target event. When the count passes 0xFFFF, it raises an overflow event. A channel in wrap mode returns to zero on a target event instead of running on. Each event sets sticky flags in the channel's mode word. An enabled event also produces a one-cycle interrupt pulse. The pulse is either repeating or one-shot; a one-shot pulse is re-armed by the next mode write.

Software selects a channel and one of four registers: count, mode, target and a shared interrupt-status word. Software clears status bits by writing 1 to them. Reading a mode word clears its target and overflow flags in the same cycle. The read data is combinational. The read-clear happens at the clock edge on which `bus_re` is high.

The count is compared before it is incremented. In wrap mode the channel holds the target value for one tick period. The following tick raises the target event and reloads zero.

Top module: `itimer3`

## Requirements
- R1: After reset, every count, mode, target and status register reads 0, and `irq_pulse` is 0.
- R2: A channel counts one per tick. Channel 0 with mode bit 8 set ticks on `dot_tick`. Channel 1 with mode bit 8 set ticks on `hsync_tick`. Channel 2 with mode bit 9 set ticks once every 8 `sys_ce` cycles, where the divider restarts on a mode write. In all other cases a channel ticks on every `sys_ce` cycle.
- R3: While mode bit 0 of channel 2 is set, its count does not change except through a count write.
- R4: On a tick with count equal to target, a target event occurs. With mode bit 3 set, the count becomes 0. Otherwise the count increments. With mode bit 3 set and a target of 0, the count holds at 0 and every tick is a target event.
- R5: On a tick with count 0xFFFF, an overflow event occurs and the count wraps to 0.
- R6: A target event sets mode bit 11 and an overflow event sets mode bit 12. Either event sets mode bit 10. The flags stay set until cleared.
- R7: A mode read returns the current word, then clears bits 11 and 12 and keeps bit 10. An event in the same cycle wins over the clear. Bits 15:13 always read 0.
- R8: A mode write stores bits 9:0, clears bits 12:10, sets the count to 0 and re-arms the one-shot interrupt.
- R9: Mode bit 4 enables the interrupt on target events and bit 5 enables it on overflow events. Each enabled event gives a one-cycle `irq_pulse` one cycle after the tick. With bit 6 set, every event fires. With bit 6 clear, only the first event after a mode write fires.
- R10: Register 3 is the status word, with channels 0, 1 and 2 at bits 4, 5 and 6. A pulse sets its channel's bit. Writing 1 to a bit clears it, and a pulse in the same cycle wins.
- R11: A target write leaves the count unchanged. A count write loads the 16-bit value and takes precedence over a tick in the same cycle.
- R12: Register select values are 0 for count, 1 for mode, 2 for target and 3 for status. For registers 0 to 2, channel select 3 reads 0 and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_ce | input | 1 | System clock enable; one count step per high cycle |
| dot_tick | input | 1 | Single-cycle dot-clock tick (alternate source for channel 0) |
| hsync_tick | input | 1 | Single-cycle horizontal-sync tick (alternate source for channel 1) |
| bus_ch | input | 2 | Channel select |
| bus_reg | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; triggers the mode-flag clear |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_pulse | output | 3 | One-cycle interrupt pulse per channel |

## Verification
The bench builds the block with the default prescaler width of 3, so the divided source ticks every 8 enables. A 16-enable run therefore makes both the divider boundary and the partial-period state visible in a few cycles. `sys_ce` stays low except in explicit tick bursts, so each count is predictable exactly. Preloading a count of 0xFFFE reaches the overflow corner in two ticks. A target of 0 exercises the hold-at-zero case without long runs.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
    localparam int NCH = 3;
    localparam int CW  = 16;

    localparam logic [1:0] REG_COUNT  = 2'd0;
    localparam logic [1:0] REG_MODE   = 2'd1;
    localparam logic [1:0] REG_TARGET = 2'd2;
    localparam logic [1:0] REG_STAT   = 2'd3;

    // mode word bit positions (software-visible)
    localparam int MB_STOP    = 0;
    localparam int MB_WRAP    = 3;
    localparam int MB_IRQ_TGT = 4;
    localparam int MB_IRQ_OVF = 5;
    localparam int MB_REPEAT  = 6;
    localparam int MB_SRC_ALT = 8;
    localparam int MB_SRC_DIV = 9;
    localparam int CTL_W      = 10;
    localparam int STAT_LSB   = 4;

    typedef struct packed {
        logic ovf;
        logic hit;
        logic evt;
    } flags_t;

    function automatic logic [CW-1:0] mode_word(flags_t f, logic [CTL_W-1:0] ctl);
        return {3'b000, f.ovf, f.hit, f.evt, ctl};
    endfunction
endpackage

// File: rtl/itimer_tick_sel.sv
module itimer_tick_sel #(
    parameter int PW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_ce,
    input  logic alt_tick,
    input  logic use_alt,
    input  logic use_div,
    input  logic stop,
    input  logic restart,
    output logic tick
);
    logic [PW-1:0] pre_q;
    logic          div_tick;

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre_q <= '0;
        else if (sys_ce && !stop)
            pre_q <= pre_q + 1'b1;
    end

    assign div_tick = sys_ce && (pre_q == '1);

    always_comb begin
        if (stop)         tick = 1'b0;
        else if (use_alt) tick = alt_tick;
        else if (use_div) tick = div_tick;
        else              tick = sys_ce;
    end
endmodule

// File: rtl/itimer_chan.sv
module itimer_chan
    import itimer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          we_cnt,
    input  logic          we_mode,
    input  logic          we_tgt,
    input  logic          re_mode,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] tgt_q,
    output logic [CW-1:0] mode_rd,
    output logic          irq
);
    logic [CTL_W-1:0] ctl_q;
    flags_t           flg_q;
    logic             fired_q;
    logic             hit, ovf, fire;
    logic [CW-1:0]    cnt_nxt;

    assign hit  = tick && (cnt_q == tgt_q);
    assign ovf  = tick && (cnt_q == '1);
    assign fire = ((hit && ctl_q[MB_IRQ_TGT]) || (ovf && ctl_q[MB_IRQ_OVF]))
                  && (ctl_q[MB_REPEAT] || !fired_q);
    assign cnt_nxt = (hit && ctl_q[MB_WRAP]) ? '0 : cnt_q + 1'b1;
    assign mode_rd = mode_word(flg_q, ctl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            flg_q   <= '0;
            fired_q <= 1'b0;
            cnt_q   <= '0;
            irq     <= 1'b0;
        end else if (we_mode) begin
            ctl_q   <= wdata[CTL_W-1:0];
            flg_q   <= '0;
            fired_q <= 1'b0;
            cnt_q   <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= fire;
            if (fire) fired_q <= 1'b1;
            if (we_cnt)    cnt_q <= wdata;
            else if (tick) cnt_q <= cnt_nxt;
            flg_q.hit <= hit || (flg_q.hit && !re_mode);
            flg_q.ovf <= ovf || (flg_q.ovf && !re_mode);
            flg_q.evt <= flg_q.evt || hit || ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         tgt_q <= '0;
        else if (we_tgt) tgt_q <= wdata;
    end
endmodule

// File: rtl/itimer_irq_stat.sv
module itimer_irq_stat #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pulse,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] stat_q
);
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~(clr_we ? clr_mask : '0)) | pulse;
    end
endmodule

// File: rtl/itimer3.sv
module itimer3
    import itimer_pkg::*;
#(
    parameter int PRESC_W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sys_ce,
    input  logic          dot_tick,
    input  logic          hsync_tick,
    input  logic [1:0]    bus_ch,
    input  logic [1:0]    bus_reg,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] irq_pulse
);
    logic [NCH-1:0][CW-1:0] cnt_a, tgt_a, mode_a;
    logic [NCH-1:0]         tick_a;
    logic [NCH-1:0]         stat_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel, alt, use_div, stop;
        assign sel = (bus_ch == 2'(i));

        if (i == 0) begin : g_dot
            assign alt = dot_tick;
        end else begin : g_hs
            assign alt = hsync_tick;
        end

        if (i == NCH-1) begin : g_div
            assign use_div = mode_a[i][MB_SRC_DIV];
            assign stop    = mode_a[i][MB_STOP];
        end else begin : g_nodiv
            assign use_div = 1'b0;
            assign stop    = 1'b0;
        end

        itimer_tick_sel #(.PW(PRESC_W)) u_tick (
            .clk      (clk),
            .rst      (rst),
            .sys_ce   (sys_ce),
            .alt_tick (alt),
            .use_alt  ((i < NCH-1) && mode_a[i][MB_SRC_ALT]),
            .use_div  (use_div),
            .stop     (stop),
            .restart  (bus_we && sel && bus_reg == REG_MODE),
            .tick     (tick_a[i])
        );

        itimer_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_a[i]),
            .we_cnt  (bus_we && sel && bus_reg == REG_COUNT),
            .we_mode (bus_we && sel && bus_reg == REG_MODE),
            .we_tgt  (bus_we && sel && bus_reg == REG_TARGET),
            .re_mode (bus_re && sel && bus_reg == REG_MODE),
            .wdata   (bus_wdata),
            .cnt_q   (cnt_a[i]),
            .tgt_q   (tgt_a[i]),
            .mode_rd (mode_a[i]),
            .irq     (irq_pulse[i])
        );
    end

    itimer_irq_stat #(.N(NCH)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .pulse    (irq_pulse),
        .clr_we   (bus_we && bus_reg == REG_STAT),
        .clr_mask (bus_wdata[STAT_LSB +: NCH]),
        .stat_q   (stat_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_reg == REG_STAT) begin
            bus_rdata = CW'(stat_q) << STAT_LSB;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_ch == 2'(i)) begin
                    case (bus_reg)
                        REG_COUNT: bus_rdata = cnt_a[i];
                        REG_MODE:  bus_rdata = mode_a[i];
                        default:   bus_rdata = tgt_a[i];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/itimer3_chk.sv
module itimer3_chk
    import itimer_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             bus_ch,
    input logic [1:0]             bus_reg,
    input logic                   bus_we,
    input logic [NCH-1:0]         irq_pulse,
    input logic [NCH-1:0]         stat_q,
    input logic [NCH-1:0][CW-1:0] cnt_a,
    input logic [NCH-1:0][CW-1:0] mode_a
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R10
        stat_set_chk: assert property (@(posedge clk) disable iff (rst)
            irq_pulse[i] |=> stat_q[i]);

        // R8
        mode_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_ch == 2'(i) && bus_reg == REG_MODE)
            |=> (cnt_a[i] == '0 && mode_a[i][12:10] == 3'b000));

        // R9
        one_shot_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_pulse[i] && !mode_a[i][MB_REPEAT]
             && !(bus_we && bus_ch == 2'(i) && bus_reg == REG_MODE))
            |=> !irq_pulse[i]);

        // R6
        evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_a[i][11] || mode_a[i][12]) |-> mode_a[i][10]);
    end

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_a[NCH-1][MB_STOP] && !(bus_we && bus_ch == 2'(NCH-1)))
        |=> $stable(cnt_a[NCH-1]));
endmodule

bind itimer3 itimer3_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ch    (bus_ch),
    .bus_reg   (bus_reg),
    .bus_we    (bus_we),
    .irq_pulse (irq_pulse),
    .stat_q    (stat_q),
    .cnt_a     (cnt_a),
    .mode_a    (mode_a)
);

// File: tb/itimer3_tb.sv
module itimer3_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_ce = 1'b0, dot_tick = 1'b0, hsync_tick = 1'b0;
    logic [1:0]  bus_ch = '0, bus_reg = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_pulse;

    int checks = 0, fails = 0, pc0 = 0;
    bit done = 0;

    always #5 clk = ~clk;

    itimer3 u_dut (
        .clk(clk), .rst(rst), .sys_ce(sys_ce), .dot_tick(dot_tick),
        .hsync_tick(hsync_tick), .bus_ch(bus_ch), .bus_reg(bus_reg),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    always @(negedge clk) if (!rst && irq_pulse[0]) pc0++;

    // op: 0 write, 1 read+check, 2 sys_ce ticks, 3 dot ticks, 4 hsync ticks
    localparam int NV = 61;
    localparam logic [42:0] VEC [NV] = '{
        {3'd0, 4'd4,  2'd0, 2'd2, 16'd5,      16'd0},
        {3'd0, 4'd4,  2'd0, 2'd1, 16'h0018,   16'd0},
        {3'd2, 4'd4,  2'd0, 2'd0, 16'd5,      16'd0},
        {3'd1, 4'd4,  2'd0, 2'd0, 16'd0,      16'd5},     // R4 at target, no event yet
        {3'd2, 4'd4,  2'd0, 2'd0, 16'd1,      16'd0},
        {3'd1, 4'd4,  2'd0, 2'd0, 16'd0,      16'd0},     // R4 wrap to zero
        {3'd1, 4'd10, 2'd0, 2'd3, 16'd0,      16'h0010},  // R10 status bit 4
        {3'd1, 4'd6,  2'd0, 2'd1, 16'd0,      16'h0C18},  // R6 flags
        {3'd1, 4'd7,  2'd0, 2'd1, 16'd0,      16'h0418},  // R7 read clear
        {3'd0, 4'd10, 2'd0, 2'd3, 16'h0010,   16'd0},
        {3'd1, 4'd10, 2'd0, 2'd3, 16'd0,      16'd0},     // R10 W1C
        {3'd2, 4'd9,  2'd0, 2'd0, 16'd6,      16'd0},
        {3'd1, 4'd6,  2'd0, 2'd1, 16'd0,      16'h0C18},
        {3'd1, 4'd9,  2'd0, 2'd3, 16'd0,      16'd0},     // R9 one-shot silent
        {3'd0, 4'd2,  2'd1, 2'd1, 16'h0120,   16'd0},
        {3'd0, 4'd11, 2'd1, 2'd0, 16'hFFFE,   16'd0},
        {3'd2, 4'd2,  2'd0, 2'd0, 16'd3,      16'd0},
        {3'd1, 4'd2,  2'd1, 2'd0, 16'd0,      16'hFFFE},  // R2 hsync source ignores sys_ce
        {3'd4, 4'd2,  2'd0, 2'd0, 16'd1,      16'd0},
        {3'd1, 4'd2,  2'd1, 2'd0, 16'd0,      16'hFFFF},
        {3'd4, 4'd5,  2'd0, 2'd0, 16'd1,      16'd0},
        {3'd1, 4'd5,  2'd1, 2'd0, 16'd0,      16'd0},     // R5 overflow wrap
        {3'd1, 4'd9,  2'd1, 2'd3, 16'd0,      16'h0020},  // R9 overflow irq
        {3'd1, 4'd6,  2'd1, 2'd1, 16'd0,      16'h1520},
        {3'd0, 4'd2,  2'd2, 2'd1, 16'h0200,   16'd0},
        {3'd2, 4'd2,  2'd0, 2'd0, 16'd16,     16'd0},
        {3'd1, 4'd2,  2'd2, 2'd0, 16'd0,      16'd2},     // R2 divide by 8
        {3'd2, 4'd2,  2'd0, 2'd0, 16'd7,      16'd0},
        {3'd1, 4'd2,  2'd2, 2'd0, 16'd0,      16'd2},
        {3'd2, 4'd2,  2'd0, 2'd0, 16'd1,      16'd0},
        {3'd1, 4'd2,  2'd2, 2'd0, 16'd0,      16'd3},
        {3'd0, 4'd3,  2'd2, 2'd1, 16'h0201,   16'd0},
        {3'd2, 4'd3,  2'd0, 2'd0, 16'd10,     16'd0},
        {3'd1, 4'd3,  2'd2, 2'd0, 16'd0,      16'd0},     // R3 stopped
        {3'd0, 4'd11, 2'd2, 2'd0, 16'd7,      16'd0},
        {3'd2, 4'd3,  2'd0, 2'd0, 16'd3,      16'd0},
        {3'd1, 4'd3,  2'd2, 2'd0, 16'd0,      16'd7},
        {3'd0, 4'd11, 2'd2, 2'd2, 16'd100,    16'd0},
        {3'd1, 4'd11, 2'd2, 2'd0, 16'd0,      16'd7},     // R11 target write keeps count
        {3'd1, 4'd11, 2'd2, 2'd2, 16'd0,      16'd100},
        {3'd0, 4'd4,  2'd0, 2'd2, 16'd0,      16'd0},
        {3'd0, 4'd4,  2'd0, 2'd1, 16'h0008,   16'd0},
        {3'd2, 4'd4,  2'd0, 2'd0, 16'd4,      16'd0},
        {3'd1, 4'd4,  2'd0, 2'd0, 16'd0,      16'd0},     // R4 target 0 hold
        {3'd1, 4'd4,  2'd0, 2'd1, 16'd0,      16'h0C08},
        {3'd0, 4'd2,  2'd0, 2'd1, 16'h0100,   16'd0},
        {3'd3, 4'd2,  2'd0, 2'd0, 16'd3,      16'd0},
        {3'd2, 4'd2,  2'd0, 2'd0, 16'd2,      16'd0},
        {3'd1, 4'd2,  2'd0, 2'd0, 16'd0,      16'd3},     // R2 dot source
        {3'd0, 4'd4,  2'd0, 2'd2, 16'd2,      16'd0},
        {3'd0, 4'd4,  2'd0, 2'd1, 16'h0000,   16'd0},
        {3'd2, 4'd4,  2'd0, 2'd0, 16'd4,      16'd0},
        {3'd1, 4'd4,  2'd0, 2'd0, 16'd0,      16'd4},     // R4 free run past target
        {3'd1, 4'd6,  2'd0, 2'd1, 16'd0,      16'h0C00},
        {3'd0, 4'd8,  2'd0, 2'd1, 16'h0000,   16'd0},
        {3'd1, 4'd8,  2'd0, 2'd1, 16'd0,      16'h0000},  // R8 flags cleared
        {3'd1, 4'd12, 2'd3, 2'd0, 16'd0,      16'd0},     // R12 channel 3 reads 0
        {3'd0, 4'd12, 2'd3, 2'd2, 16'h1234,   16'd0},
        {3'd1, 4'd12, 2'd0, 2'd2, 16'd0,      16'd2},
        {3'd1, 4'd12, 2'd1, 2'd2, 16'd0,      16'd0},
        {3'd1, 4'd12, 2'd2, 2'd2, 16'd0,      16'd100}
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] rg, input logic [15:0] d);
        bus_ch = ch; bus_reg = rg; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int req, input logic [1:0] ch, input logic [1:0] rg,
                      input logic [15:0] exp);
        bus_ch = ch; bus_reg = rg; bus_re = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic pulse_src(input int sel, input int n);
        if (sel == 2) sys_ce = 1'b1;
        if (sel == 3) dot_tick = 1'b1;
        if (sel == 4) hsync_tick = 1'b1;
        repeat (n) @(negedge clk);
        sys_ce = 1'b0; dot_tick = 1'b0; hsync_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        for (int v = 0; v < NV; v++) begin
            case (VEC[v][42:40])
                3'd0: wr(VEC[v][35:34], VEC[v][33:32], VEC[v][31:16]);
                3'd1: rd(int'(VEC[v][39:36]), VEC[v][35:34], VEC[v][33:32], VEC[v][15:0]);
                default: pulse_src(int'(VEC[v][42:40]), int'(VEC[v][31:16]));
            endcase
        end

        // R1: reset state
        do_reset();
        for (int c = 0; c < 3; c++)
            for (int r = 0; r < 3; r++)
                rd(1, 2'(c), 2'(r), 16'd0);
        rd(1, 2'd0, 2'd3, 16'd0);
        chk(1, {13'd0, irq_pulse}, 16'd0);

        // R9: repeating interrupt, two target events give two pulses
        wr(2'd0, 2'd2, 16'd5);
        wr(2'd0, 2'd1, 16'h0058);
        pc0 = 0;
        pulse_src(2, 12);
        repeat (2) @(negedge clk);
        chk(9, 16'(pc0), 16'd2);

        // R9: one-shot interrupt, same stimulus gives a single pulse
        wr(2'd0, 2'd1, 16'h0018);
        pc0 = 0;
        pulse_src(2, 12);
        repeat (2) @(negedge clk);
        chk(9, 16'(pc0), 16'd1);

        // R10: clear and set in same cycle, set wins
        wr(2'd0, 2'd3, 16'h0070);
        wr(2'd0, 2'd1, 16'h0058);
        sys_ce = 1'b1;
        repeat (5) @(negedge clk);
        @(negedge clk);          // tick at target: pulse follows
        sys_ce = 1'b0;
        wr(2'd0, 2'd3, 16'h0010); // pulse high during this write
        rd(10, 2'd0, 2'd3, 16'h0010);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule